// File: doc/BRIEF.md
# Two-Register Serial Command Slave

This block is a slave on a two-wire serial bus (I2C). It holds two 8-bit setting registers, a shutdown level and two general-purpose output bits. A fast system clock oversamples the bus clock (SCL) and data (SDA) lines. The block finds start and stop conditions and answers a 7-bit address. The top five bits of that address are fixed at 01011. The low two bits come from two strap pins.

A write transaction has three bytes. The first is the address byte with R/W low. Next comes an instruction byte, which selects a register and carries a midscale-reset bit, a shutdown bit and two output-latch bits. Last comes a data byte for the selected register. A read transaction has two bytes. The first is the address byte with R/W high. The slave then sends the register that the last write selected. It drives SDA only low, through an open-drain output enable.

Top module: `dual_reg_i2c_slave`

## Requirements
- R1: After reset, both registers read 8'h80, the shutdown level and both output bits are 0, register 1 is selected and `sda_oe` is 0.
- R2: An address byte whose bits, MSB first, are 0,1,0,1,1 and then `strap_addr[1]`, `strap_addr[0]` is acknowledged: `sda_oe` pulls SDA low during the 9th SCL clock. The 8th bit is R/W, with 1 meaning read and 0 meaning write.
- R3: If the address does not match, the slave never pulls SDA. It ignores all further bytes until the next start or stop, so its outputs do not change.
- R4: Instruction byte fields are bit 7 for the register select (0 selects register 1, 1 selects register 2), bit 6 for midscale reset, bit 5 for shutdown, bit 4 for output 1 and bit 3 for output 2. Bits 2:0 are ignored. The select, shutdown and output bits take effect at the instruction byte's acknowledge, even when no data byte follows.
- R5: The data byte is written to the selected register at its acknowledge. The other register keeps its value.
- R6: With the reset bit set, the selected register becomes 8'h80, and the data byte of the same transaction is discarded.
- R7: A read returns the selected register MSB first.
- R8: In a write, the slave acknowledges the address, instruction and data bytes. In a read, it leaves SDA released during the 9th clock of the data byte.
- R9: SDA is driven only low. The slave changes the driven value only while SCL is low, so SDA stays stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| strap_addr | input | 2 | Low two address bits from strap pins |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg1_q | output | 8 | Setting register 1 |
| reg2_q | output | 8 | Setting register 2 |
| shdn_q | output | 1 | Shutdown level |
| gpo1_q | output | 1 | Latched output bit 1 |
| gpo2_q | output | 1 | Latched output bit 2 |

## Verification
Each bus line edge passes through two synchronizer flops and one edge-detect flop before the state machine registers its action. So `sda_oe` and the latched outputs settle about four system clocks after the SCL falling edge that starts an acknowledge clock. The bench holds every SCL phase for twelve system clocks. It samples SDA mid-way through SCL high, and again right after SCL rises and just before it falls, so both samples lie well clear of that delay. Register and control outputs are compared with the bench model only after the stop condition, when every update has long settled.

// File: rtl/dreg_i2c_pkg.sv
// Shared constants and types for the two-register serial command slave.
// Assumes byte-wide frames and exactly two setting registers.
package dreg_i2c_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_SLOTS = 2;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int CNT_W     = $clog2(BYTE_W + 1);
    localparam int ADDR_W    = 7;
    localparam int STRAP_W   = 2;
    localparam int PREFIX_W  = ADDR_W - STRAP_W;
    // instruction byte field positions (decoded by the bank)
    localparam int F_SEL = 7;
    localparam int F_RS  = 6;
    localparam int F_SD  = 5;
    localparam int F_O1  = 4;
    localparam int F_O2  = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_INSTR, ST_WDATA, ST_RDATA, ST_ACK, ST_WAIT
    } slv_state_e;
endpackage

// File: rtl/dreg_line_cond.sv
// Bus line conditioner: synchronizes SCL and SDA and flags SCL edges and
// start/stop conditions, each as a one-cycle pulse.
// Assumes SYNC_STAGES >= 2 and a system clock far faster than SCL.
module dreg_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
    logic scl_prev, sda_prev;

    // synchronizer chains plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    // edge and bus-condition decode
    always_comb begin
        scl_lvl   = scl_sync[SYNC_STAGES-1];
        sda_lvl   = sda_sync[SYNC_STAGES-1];
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end
endmodule

// File: rtl/dreg_cmd_fsm.sv
// Frame engine: shifts bytes in on SCL rising edges, decides the acknowledge
// at the SCL fall after the 8th bit, drives read data on SCL falls, and
// issues write strobes to the register bank at the acknowledges.
// Assumes conditioned single-cycle edge pulses from dreg_line_cond.
module dreg_cmd_fsm
    import dreg_i2c_pkg::*;
#(
    parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b01011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_lvl,
    input  logic               sda_lvl,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [STRAP_W-1:0] strap_addr,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic               instr_we,
    output logic [SLOT_W-1:0]  instr_sel,
    output logic               instr_rs,
    output logic               instr_sd,
    output logic               instr_o1,
    output logic               instr_o2,
    output logic               data_we,
    output logic [BYTE_W-1:0]  data_byte
);
    slv_state_e         state, after;
    logic [CNT_W-1:0]   cnt;
    logic [BYTE_W-1:0]  shreg, tx;
    logic               rs_pend;
    logic               addr_hit, byte_done;

    // address match and end-of-byte decode
    always_comb begin
        addr_hit  = (shreg[BYTE_W-1:1] == {ADDR_PREFIX, strap_addr});
        byte_done = scl_fall && (cnt == CNT_W'(BYTE_W));
    end

    // frame sequencing, acknowledge and transmit shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            after    <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            tx       <= '1;
            sda_oe   <= 1'b0;
            rs_pend  <= 1'b0;
            instr_we <= 1'b0;
            data_we  <= 1'b0;
        end else begin
            instr_we <= 1'b0;
            data_we  <= 1'b0;
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                cnt    <= '0;
            end else if (start_det) begin
                state   <= ST_ADDR;
                sda_oe  <= 1'b0;
                cnt     <= '0;
                rs_pend <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_INSTR, ST_WDATA: begin
                        if (scl_rise && cnt != CNT_W'(BYTE_W)) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_lvl};
                            cnt   <= cnt + CNT_W'(1);
                        end else if (byte_done) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit) begin
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                    after  <= shreg[0] ? ST_RDATA : ST_INSTR;
                                end else begin
                                    state <= ST_WAIT;
                                end
                            end else if (state == ST_INSTR) begin
                                sda_oe   <= 1'b1;
                                state    <= ST_ACK;
                                after    <= ST_WDATA;
                                instr_we <= 1'b1;
                                rs_pend  <= shreg[F_RS];
                            end else begin
                                sda_oe  <= 1'b1;
                                state   <= ST_ACK;
                                after   <= ST_WAIT;
                                data_we <= !rs_pend;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            state <= after;
                            if (after == ST_RDATA) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            tx     <= {tx[BYTE_W-2:0], 1'b1};
                            sda_oe <= ~tx[BYTE_W-2];
                        end else if (scl_rise) begin
                            if (cnt == CNT_W'(BYTE_W)) begin
                                state  <= ST_WAIT;
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                            end else begin
                                cnt <= cnt + CNT_W'(1);
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // instruction fields and data byte presented with the strobes
    always_comb begin
        instr_sel = SLOT_W'(shreg[F_SEL]);
        instr_rs  = shreg[F_RS];
        instr_sd  = shreg[F_SD];
        instr_o1  = shreg[F_O1];
        instr_o2  = shreg[F_O2];
        data_byte = shreg;
    end

    // R9
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);
    // R3
    wait_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !sda_oe);
    // R8
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK && !scl_fall && !start_det && !stop_det) |=> sda_oe);
endmodule

// File: rtl/dreg_bank.sv
// Setting register bank: two byte registers plus select, shutdown and
// output latches, written by strobes from the frame engine.
// Assumes instr_we and data_we never pulse in the same cycle.
module dreg_bank
    import dreg_i2c_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MIDSCALE = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_we,
    input  logic [SLOT_W-1:0] instr_sel,
    input  logic              instr_rs,
    input  logic              instr_sd,
    input  logic              instr_o1,
    input  logic              instr_o2,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] data_in,
    output logic [BYTE_W-1:0] slot_q [NUM_SLOTS],
    output logic [BYTE_W-1:0] rd_data,
    output logic              shdn_q,
    output logic              gpo1_q,
    output logic              gpo2_q
);
    logic [SLOT_W-1:0] sel_q;

    // control latches, updated at the instruction acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            shdn_q <= 1'b0;
            gpo1_q <= 1'b0;
            gpo2_q <= 1'b0;
        end else if (instr_we) begin
            sel_q  <= instr_sel;
            shdn_q <= instr_sd;
            gpo1_q <= instr_o1;
            gpo2_q <= instr_o2;
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        // one setting register: midscale reset or data write
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= MIDSCALE;
            else if (instr_we && instr_rs && instr_sel == SLOT_W'(g))
                slot_q[g] <= MIDSCALE;
            else if (data_we && sel_q == SLOT_W'(g))
                slot_q[g] <= data_in;
        end

        // R6
        rs_midscale_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (instr_we && instr_rs && instr_sel == SLOT_W'(g)) |=> slot_q[g] == MIDSCALE);
        // R5
        data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (data_we && sel_q == SLOT_W'(g)) |=> slot_q[g] == $past(data_in));
    end

    // read source follows the current selection
    always_comb rd_data = slot_q[sel_q];
endmodule

// File: rtl/dual_reg_i2c_slave.sv
// Top of the two-register serial command slave: line conditioner, frame
// engine and register bank. Assumes SCL far slower than clk (at least
// about ten clk periods per SCL phase) and no clock stretching.
module dual_reg_i2c_slave
    import dreg_i2c_pkg::*;
#(
    parameter int                  SYNC_STAGES = 2,
    parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b01011,
    parameter logic [BYTE_W-1:0]   MIDSCALE    = 8'h80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [STRAP_W-1:0] strap_addr,
    output logic               sda_oe,
    output logic [BYTE_W-1:0]  reg1_q,
    output logic [BYTE_W-1:0]  reg2_q,
    output logic               shdn_q,
    output logic               gpo1_q,
    output logic               gpo2_q
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic instr_we, instr_rs, instr_sd, instr_o1, instr_o2, data_we;
    logic [SLOT_W-1:0] instr_sel;
    logic [BYTE_W-1:0] data_byte, rd_data;
    logic [BYTE_W-1:0] slot_q [NUM_SLOTS];

    dreg_line_cond #(.SYNC_STAGES(SYNC_STAGES)) cond_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det));

    dreg_cmd_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) fsm_i (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .strap_addr(strap_addr), .rd_data(rd_data),
        .sda_oe(sda_oe), .instr_we(instr_we), .instr_sel(instr_sel),
        .instr_rs(instr_rs), .instr_sd(instr_sd), .instr_o1(instr_o1),
        .instr_o2(instr_o2), .data_we(data_we), .data_byte(data_byte));

    dreg_bank #(.MIDSCALE(MIDSCALE)) bank_i (
        .clk(clk), .rst_n(rst_n), .instr_we(instr_we), .instr_sel(instr_sel),
        .instr_rs(instr_rs), .instr_sd(instr_sd), .instr_o1(instr_o1),
        .instr_o2(instr_o2), .data_we(data_we), .data_in(data_byte),
        .slot_q(slot_q), .rd_data(rd_data), .shdn_q(shdn_q),
        .gpo1_q(gpo1_q), .gpo2_q(gpo2_q));

    // expose the two setting registers
    always_comb begin
        reg1_q = slot_q[0];
        reg2_q = slot_q[1];
    end
endmodule

// File: tb/dual_reg_i2c_slave_tb_top.sv
// Self-checking bench: bus master model, reference model, directed cases
// and seeded random transactions.
module dual_reg_i2c_slave_tb_top;
    localparam int Q = 12;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] strap = 2'b00;
    logic sda_oe, shdn_q, gpo1_q, gpo2_q, sda_bus;
    logic [7:0] reg1_q, reg2_q;
    int n_chk = 0, n_err = 0;
    bit done = 1'b0;
    logic [7:0] exp_reg [2];
    logic exp_sel, exp_sd, exp_o1, exp_o2;

    always #5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    dual_reg_i2c_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .strap_addr(strap), .sda_oe(sda_oe), .reg1_q(reg1_q), .reg2_q(reg2_q),
        .shdn_q(shdn_q), .gpo1_q(gpo1_q), .gpo2_q(gpo2_q));

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit addr_ok(input logic [6:0] a, input logic [1:0] s);
        return a == {5'b01011, s};
    endfunction

    task automatic model_write(input logic [7:0] ins, input logic [7:0] d, input bit full);
        exp_sel = ins[7]; exp_sd = ins[5]; exp_o1 = ins[4]; exp_o2 = ins[3];
        if (ins[6]) exp_reg[exp_sel] = 8'h80;
        else if (full) exp_reg[exp_sel] = d;
    endtask

    task automatic chk_outputs(input string tag);
        chk(reg1_q == exp_reg[0], tag, reg1_q, exp_reg[0]);
        chk(reg2_q == exp_reg[1], tag, reg2_q, exp_reg[1]);
        chk(shdn_q == exp_sd, tag, shdn_q, exp_sd);
        chk({gpo1_q, gpo2_q} == {exp_o1, exp_o2}, tag, {gpo1_q, gpo2_q}, {exp_o1, exp_o2});
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; scl_m = 1'b1; w(Q);
        sda_m = 1'b0; w(Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b1; w(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; w(Q);
            scl_m = 1'b1; w(Q);
            scl_m = 1'b0; w(Q);
        end
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q / 2);
        acked = !sda_bus;
        w(Q / 2);
        scl_m = 1'b0; w(Q);
    endtask

    // receive one byte, then nack; stable flags SDA constant in SCL high
    task automatic recv_byte(output logic [7:0] b, output bit stable, output bit released);
        logic v0, v1;
        stable = 1'b1;
        sda_m = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            w(Q);
            scl_m = 1'b1; w(2);
            v0 = sda_bus; w(Q - 3);
            v1 = sda_bus; w(1);
            if (v0 != v1) stable = 1'b0;
            b = {b[6:0], v1};
            scl_m = 1'b0;
        end
        w(Q);
        scl_m = 1'b1; w(Q / 2);
        released = sda_bus;
        w(Q / 2);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] ins, input logic [7:0] d,
                            output bit k0, output bit k1, output bit k2);
        i2c_start();
        send_byte({a, 1'b0}, k0);
        send_byte(ins, k1);
        send_byte(d, k2);
        i2c_stop();
        w(Q);
    endtask

    task automatic do_read(input logic [6:0] a, output logic [7:0] b, output bit k0,
                           output bit stable, output bit released);
        i2c_start();
        send_byte({a, 1'b1}, k0);
        recv_byte(b, stable, released);
        i2c_stop();
        w(Q);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        bit k0, k1, k2, st, rl;
        logic [7:0] rb, ins, d;
        logic [6:0] a;
        exp_reg[0] = 8'h80; exp_reg[1] = 8'h80;
        exp_sel = 1'b0; exp_sd = 1'b0; exp_o1 = 1'b0; exp_o2 = 1'b0;
        void'($urandom(32'h5eed_1234));
        w(5); rst_n = 1'b1; w(5);
        // R1 reset state
        chk_outputs("R1");
        chk(sda_oe == 1'b0, "R1", sda_oe, 0);
        do_read({5'b01011, strap}, rb, k0, st, rl);
        chk(rb == 8'h80, "R1 read after reset", rb, 8'h80);

        // R2 R5 R4 R8: write register 2 with shutdown set
        strap = 2'b10;
        do_write({5'b01011, 2'b10}, 8'hA0, 8'h3C, k0, k1, k2);
        model_write(8'hA0, 8'h3C, 1'b1);
        chk(k0, "R2 address ack", k0, 1);
        chk(k1 && k2, "R8 write acks", {k1, k2}, 2'b11);
        chk_outputs("R5");

        // R7 R8 R9: read back register 2
        do_read({5'b01011, 2'b10}, rb, k0, st, rl);
        chk(rb == 8'h3C, "R7 read data", rb, 8'h3C);
        chk(rl, "R8 nack clock released", rl, 1);
        chk(st, "R9 stable while SCL high", st, 1);

        // R6: reset bit beats data byte
        do_write({5'b01011, 2'b10}, 8'hC0, 8'h11, k0, k1, k2);
        model_write(8'hC0, 8'h11, 1'b1);
        chk_outputs("R6");

        // R3: wrong strap bits, then trailing bytes ignored
        do_write({5'b01011, 2'b01}, 8'h18, 8'h55, k0, k1, k2);
        chk({k0, k1, k2} == 3'b000, "R3 no ack", {k0, k1, k2}, 0);
        chk_outputs("R3");

        // R4: don't-care bits, outputs updated at instruction ack without data
        i2c_start();
        send_byte({5'b01011, 2'b10, 1'b0}, k0);
        send_byte(8'h1F, k1);
        i2c_stop(); w(Q);
        model_write(8'h1F, 8'h00, 1'b0);
        chk_outputs("R4");
        do_read({5'b01011, 2'b10}, rb, k0, st, rl);
        chk(rb == exp_reg[0], "R4 select reg1", rb, exp_reg[0]);

        // random mix
        for (int t = 0; t < 40; t++) begin
            strap = 2'($urandom);
            a = ($urandom % 8 != 0) ? {5'b01011, strap} : 7'($urandom);
            ins = 8'($urandom);
            d = 8'($urandom);
            if ($urandom % 4 == 0) begin
                do_read(a, rb, k0, st, rl);
                chk(k0 == addr_ok(a, strap), "R2 rand read ack", k0, addr_ok(a, strap));
                if (addr_ok(a, strap)) begin
                    chk(rb == exp_reg[exp_sel], "R7 rand read", rb, exp_reg[exp_sel]);
                    chk(st, "R9 rand stable", st, 1);
                end
            end else begin
                do_write(a, ins, d, k0, k1, k2);
                if (addr_ok(a, strap)) begin
                    model_write(ins, d, 1'b1);
                    chk({k0, k1, k2} == 3'b111, "R8 rand acks", {k0, k1, k2}, 3'b111);
                end else begin
                    chk({k0, k1, k2} == 3'b000, "R3 rand no ack", {k0, k1, k2}, 0);
                end
                chk_outputs("R5 rand");
            end
        end
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
            $finish;
        end
    end
endmodule